// File: doc/BRIEF.md
# Staged Power-Up Sequencer

This block is the control state machine of a power management controller. While the system is off it rests in a standby state. In standby only the always-on clock-domain supply is driven, and the processor is held in reset. Three events can start a boot: a charger attach edge, a battery insertion edge, or a power-key press that has been held stable long enough. After any of them, the sequencer turns on supply groups one at a time in a fixed order. It moves to the next group only when the current one reports power-good.

The order is fixed:

1. System supply group.
2. Main battery distribution group.
3. Crystal clock enable.
4. Core logic rails.
5. Memory rails.
6. Storage rails.
7. Radio rails.
8. Display, touch, camera and audio rails.

The processor reset is released only once the core rails are good. The storage device reset is released once storage power is good. After the last group, the block waits for the processor to raise its keep-alive line.

Each stage is timed by a cycle limit taken from an input. The number of a stage that misses its limit is latched as a fault code. Radio and peripheral faults are recorded and the sequence continues. Any other stage fault, a missing keep-alive, or a keep-alive drop while running starts a shutdown. The shutdown asserts both resets and removes the enabled groups one per cycle, last-enabled first, before returning to standby.

Top module: `pwr_seq_top`

States and their `seq_status` codes:

| Code | State | Meaning |
|---|---|---|
| 0 | STANDBY | Off |
| 1 | SUPPLY | System supply group |
| 2 | MAIN | Main battery distribution |
| 3 | CLOCK | Crystal clock |
| 4 | CORE | Core logic rails |
| 5 | MEM | Memory rails |
| 6 | STORE | Storage rails |
| 7 | RADIO | Radio rails |
| 8 | PERIPH | Display, touch, camera and audio rails |
| 9 | HANDSHAKE | Waiting for keep-alive |
| 10 | RUN | Running |
| 11 | SHUTDOWN | Removing groups |

Transitions:

| From | To | When |
|---|---|---|
| STANDBY | SUPPLY | Wake |
| Stage k (codes 1 to 8) | Stage k+1 | Good |
| Stage k (codes 1 to 8) | Stage k+1 | Timeout on RADIO or PERIPH |
| Stage k (codes 1 to 8) | SHUTDOWN | Timeout on any other stage |
| PERIPH | HANDSHAKE | Good |
| HANDSHAKE | RUN | Keep-alive high |
| HANDSHAKE | SHUTDOWN | Timeout |
| RUN | SHUTDOWN | Keep-alive low |
| SHUTDOWN | STANDBY | All groups off |

## Requirements
- R1: After reset the block is in STANDBY with these outputs:
  - `seq_status` = 0, `fault_code` = 0 and `rtc_en` = 1.
  - Every `rail_en` bit and `xtal_en` are 0.
  - `cpu_rst_n` = 0 and `store_rst_n` = 0.
- R2: In STANDBY, a 0-to-1 change on `chg_det` or on `bat_ins`, or a debounced key press, moves the block to SUPPLY (code 1) on the next edge and clears `fault_code` to 0.
- R3: A key press counts only after `key_in` has been high for DEB_CYC consecutive edges. A shorter pulse does not wake the block.
- R4: The combined enable vector is E = {`rail_en`[6:2], `xtal_en`, `rail_en`[1:0]}.
  - In stage code k (1 to 8), E has bits k-1..0 set.
  - In HANDSHAKE and RUN, E is all ones.
  - E always has the form 2^n-1.
  - Stage k advances only when its good input is high. Stages 1 and 2 use `pg_in`[0] and [1], stage 3 uses `clk_ready`, and stages 4 to 8 use `pg_in`[2] to [6].
- R5: `cpu_rst_n` is 1 only in MEM, STORE, RADIO, PERIPH, HANDSHAKE and RUN. `keep_alive` has no effect before HANDSHAKE, so a boot with it held high still passes through HANDSHAKE.
- R6: `store_rst_n` is 1 only in RADIO, PERIPH, HANDSHAKE and RUN, that is, after storage power-good.
- R7: A stage whose good input stays low leaves after exactly `pg_limit`+1 edges and sets `fault_code` to its stage code.
- R8: A timeout in stages 1 to 6 enters SHUTDOWN with E unchanged on the entry cycle. A timeout in RADIO (7) or PERIPH (8) advances to the next stage and keeps its enable set.
- R9: HANDSHAKE goes to RUN on the edge after `keep_alive` is high. With `keep_alive` low it leaves after KA_TIMEOUT+1 edges for SHUTDOWN with `fault_code` = 9.
- R10: When `keep_alive` is low in RUN, the next edge enters SHUTDOWN with `fault_code` = 10.
- R11: SHUTDOWN behaves as follows:
  - Both resets are asserted at once.
  - Each edge clears the highest set bit of E.
  - The edge after E reaches 0 returns to STANDBY.
  - `fault_code` keeps its value until the next wake.
- R12: Wake events outside STANDBY are ignored. The state and the fault code do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 1 | Raw power-key level, synchronous |
| chg_det | input | 1 | Charger supply detected level |
| bat_ins | input | 1 | Battery inserted level |
| pg_in | input | 7 | Power-good per group: supply, main, core, memory, storage, radio, peripheral |
| clk_ready | input | 1 | Crystal clock running |
| keep_alive | input | 1 | Processor keep-alive |
| pg_limit | input | LIMIT_W | Stage timeout in cycles |
| rtc_en | output | 1 | Always-on clock-domain enable |
| rail_en | output | 7 | Group enables, same order as pg_in |
| xtal_en | output | 1 | Crystal clock enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| store_rst_n | output | 1 | Storage device reset, active low |
| seq_status | output | 4 | Current state code |
| fault_code | output | 4 | Last fault: stage code, 9 or 10, 0 for none |

## Verification
The assertions check on every cycle that:
- the enable vector stays a contiguous run from bit 0;
- neither reset is released without the rails beneath it;
- RUN is entered only after keep-alive was high;
- shutdown removes exactly one group per edge;
- any entry into SHUTDOWN carries a nonzero fault code.

The exact stage and handshake timeout lengths, the debounce count, and the choice between continuing and aborting after a fault can only be shown by the bench scenarios. The same holds for fault retention across standby and for wake events being ignored mid-sequence.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        S_STANDBY   = 4'd0,
        S_SUPPLY    = 4'd1,
        S_MAIN      = 4'd2,
        S_CLOCK     = 4'd3,
        S_CORE      = 4'd4,
        S_MEM       = 4'd5,
        S_STORE     = 4'd6,
        S_RADIO     = 4'd7,
        S_PERIPH    = 4'd8,
        S_HANDSHAKE = 4'd9,
        S_RUN       = 4'd10,
        S_SHUTDOWN  = 4'd11
    } seq_state_e;

    localparam int NUM_STAGE = 8;   // enable stages incl. clock
    localparam int NUM_GRP   = 7;   // power-good reporting groups
    localparam int CLK_BIT   = 2;   // position of clock stage in stage vector

    localparam logic [3:0] FLT_NONE    = 4'd0;
    localparam logic [3:0] FLT_KA_MISS = 4'd9;
    localparam logic [3:0] FLT_KA_DROP = 4'd10;

    // Stages whose timeout is logged but does not stop the boot
    function automatic logic is_soft(input seq_state_e s);
        return (s == S_RADIO) || (s == S_PERIPH);
    endfunction

    // Enable vector while sitting in stage code s (1..8)
    function automatic logic [NUM_STAGE-1:0] stage_mask(input logic [3:0] s);
        logic [NUM_STAGE:0] m;
        m = ({{NUM_STAGE{1'b0}}, 1'b1} << s) - 1'b1;
        return m[NUM_STAGE-1:0];
    endfunction

    // Clear highest set bit
    function automatic logic [NUM_STAGE-1:0] drop_top(input logic [NUM_STAGE-1:0] m);
        logic [NUM_STAGE-1:0] r;
        logic                 done;
        r    = m;
        done = 1'b0;
        for (int i = NUM_STAGE - 1; i >= 0; i--) begin
            if (!done && m[i]) begin
                r[i] = 1'b0;
                done = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pwr_seq_debounce.sv
module pwr_seq_debounce #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_in,
    output logic press_evt
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] run_cnt;
    logic          held;
    logic          held_q;

    assign held = (run_cnt == CW'(HOLD_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            held_q  <= 1'b0;
        end else begin
            held_q <= held;
            if (!key_in)
                run_cnt <= '0;
            else if (!held)
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign press_evt = held & ~held_q;

endmodule

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake #(
    parameter int unsigned HOLD_CYC = 16,
    parameter int unsigned NUM_LVL  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_in,
    input  logic [NUM_LVL-1:0] lvl_in,
    output logic               wake
);
    logic               key_evt;
    logic [NUM_LVL-1:0] lvl_q;
    logic [NUM_LVL-1:0] lvl_evt;

    pwr_seq_debounce #(.HOLD_CYC(HOLD_CYC)) u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_in    (key_in),
        .press_evt (key_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_in;
    end

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_rise
            assign lvl_evt[g] = lvl_in[g] & ~lvl_q[g];
        end
    endgenerate

    assign wake = key_evt | (|lvl_evt);

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != {TW{1'b1}})
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int unsigned DEB_CYC    = 16,
    parameter int          LIMIT_W    = 16,
    parameter int unsigned KA_TIMEOUT = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_in,
    input  logic               chg_det,
    input  logic               bat_ins,
    input  logic [6:0]         pg_in,
    input  logic               clk_ready,
    input  logic               keep_alive,
    input  logic [LIMIT_W-1:0] pg_limit,
    output logic               rtc_en,
    output logic [6:0]         rail_en,
    output logic               xtal_en,
    output logic               cpu_rst_n,
    output logic               store_rst_n,
    output logic [3:0]         seq_status,
    output logic [3:0]         fault_code
);
    localparam int KA_W = $clog2(KA_TIMEOUT + 1);
    localparam int TW   = (KA_W > LIMIT_W) ? KA_W : LIMIT_W;

    seq_state_e           state, state_nx;
    logic                 wake;
    logic                 expired;
    logic [TW-1:0]        limit_sel;
    logic                 stage_ok;
    logic                 flt_set;
    logic [3:0]           flt_val;
    logic [NUM_STAGE-1:0] en_now;
    logic [NUM_STAGE-1:0] sd_mask;
    logic [3:0]           fault_q;

    pwr_seq_wake #(.HOLD_CYC(DEB_CYC), .NUM_LVL(2)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_in (key_in),
        .lvl_in ({bat_ins, chg_det}),
        .wake   (wake)
    );

    assign limit_sel = (state == S_HANDSHAKE) ? TW'(KA_TIMEOUT) : TW'(pg_limit);

    pwr_seq_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_nx != state),
        .limit   (limit_sel),
        .expired (expired)
    );

    // Good condition of the stage currently being powered
    always_comb begin
        case (state)
            S_SUPPLY: stage_ok = pg_in[0];
            S_MAIN:   stage_ok = pg_in[1];
            S_CLOCK:  stage_ok = clk_ready;
            S_CORE:   stage_ok = pg_in[2];
            S_MEM:    stage_ok = pg_in[3];
            S_STORE:  stage_ok = pg_in[4];
            S_RADIO:  stage_ok = pg_in[5];
            S_PERIPH: stage_ok = pg_in[6];
            default:  stage_ok = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_STANDBY;
        else        state <= state_nx;
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        flt_set  = 1'b0;
        flt_val  = FLT_NONE;
        unique case (state)
            S_STANDBY: begin
                if (wake) state_nx = S_SUPPLY;
            end
            S_SUPPLY, S_MAIN, S_CLOCK, S_CORE,
            S_MEM, S_STORE, S_RADIO, S_PERIPH: begin
                if (stage_ok) begin
                    state_nx = seq_state_e'(state + 4'd1);
                end else if (expired) begin
                    flt_set  = 1'b1;
                    flt_val  = state;
                    state_nx = is_soft(state) ? seq_state_e'(state + 4'd1) : S_SHUTDOWN;
                end
            end
            S_HANDSHAKE: begin
                if (keep_alive) begin
                    state_nx = S_RUN;
                end else if (expired) begin
                    flt_set  = 1'b1;
                    flt_val  = FLT_KA_MISS;
                    state_nx = S_SHUTDOWN;
                end
            end
            S_RUN: begin
                if (!keep_alive) begin
                    flt_set  = 1'b1;
                    flt_val  = FLT_KA_DROP;
                    state_nx = S_SHUTDOWN;
                end
            end
            S_SHUTDOWN: begin
                if (sd_mask == '0) state_nx = S_STANDBY;
            end
            default: state_nx = S_SHUTDOWN;
        endcase
    end

    // Enable vector per state
    always_comb begin
        unique case (state)
            S_STANDBY:             en_now = '0;
            S_HANDSHAKE, S_RUN:    en_now = '1;
            S_SHUTDOWN:            en_now = sd_mask;
            default:               en_now = stage_mask(state);
        endcase
    end

    // Shutdown mask and fault register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_mask <= '0;
            fault_q <= FLT_NONE;
        end else begin
            if (state != S_SHUTDOWN && state_nx == S_SHUTDOWN)
                sd_mask <= en_now;
            else if (state == S_SHUTDOWN)
                sd_mask <= drop_top(sd_mask);

            if (state == S_STANDBY && wake)
                fault_q <= FLT_NONE;
            else if (flt_set)
                fault_q <= flt_val;
        end
    end

    // Outputs
    always_comb begin
        rtc_en      = 1'b1;
        rail_en     = {en_now[NUM_STAGE-1:CLK_BIT+1], en_now[CLK_BIT-1:0]};
        xtal_en     = en_now[CLK_BIT];
        cpu_rst_n   = (state >= S_MEM) && (state <= S_RUN);
        store_rst_n = (state >= S_RADIO) && (state <= S_RUN);
        seq_status  = state;
        fault_code  = fault_q;
    end

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       keep_alive,
    input logic [6:0] rail_en,
    input logic       xtal_en,
    input logic       cpu_rst_n,
    input logic       store_rst_n,
    input logic [3:0] seq_status,
    input logic [3:0] fault_code
);
    logic [7:0] en8;
    assign en8 = {rail_en[6:2], xtal_en, rail_en[1:0]};

    p_standby_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_status == 4'd0) |-> (en8 == 8'h00 && !cpu_rst_n && !store_rst_n));

    p_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((en8 & (en8 + 8'd1)) == 8'h00));

    p_cpu_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |-> (en8[3] && en8[2]));

    p_store_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_rst_n |-> (en8[5] && cpu_rst_n));

    p_abort_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_status == 4'd11 && $past(seq_status) != 4'd11) |-> (fault_code != 4'd0));

    p_run_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_status == 4'd10 && $past(seq_status) != 4'd10) |-> $past(keep_alive));

    p_ka_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_status == 4'd10 && !keep_alive) |=> (seq_status == 4'd11));

    p_shut_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_status == 4'd11 && $past(seq_status) == 4'd11) |->
        (($past(en8) == 8'h00) || ($countones($past(en8)) == $countones(en8) + 1)));

endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .keep_alive  (keep_alive),
    .rail_en     (rail_en),
    .xtal_en     (xtal_en),
    .cpu_rst_n   (cpu_rst_n),
    .store_rst_n (store_rst_n),
    .seq_status  (seq_status),
    .fault_code  (fault_code)
);

// File: tb/pwr_seq_top_bench.sv
module pwr_seq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int KA_TO      = 12;
    localparam int LIM        = 5;
    localparam int NVEC       = 23;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       key_in, chg_det, bat_ins, clk_ready, keep_alive;
    logic [6:0] pg_in;
    logic [7:0] pg_limit;
    logic       rtc_en, xtal_en, cpu_rst_n, store_rst_n;
    logic [6:0] rail_en;
    logic [3:0] seq_status, fault_code;
    logic [7:0] en8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign en8 = {rail_en[6:2], xtal_en, rail_en[1:0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_seq_top #(.DEB_CYC(DEB), .LIMIT_W(8), .KA_TIMEOUT(KA_TO)) u_pwr_seq_top (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .chg_det(chg_det), .bat_ins(bat_ins),
        .pg_in(pg_in), .clk_ready(clk_ready), .keep_alive(keep_alive), .pg_limit(pg_limit),
        .rtc_en(rtc_en), .rail_en(rail_en), .xtal_en(xtal_en), .cpu_rst_n(cpu_rst_n),
        .store_rst_n(store_rst_n), .seq_status(seq_status), .fault_code(fault_code)
    );

    // {key,chg,bat,pg[6:0],clk_ready,ka} | {status,en8,cpu_rst_n,store_rst_n,fault}
    localparam logic [29:0] BOOT_VEC [NVEC] = '{
        {3'b010, 7'h00, 2'b00,  4'd1,  8'h01, 2'b00, 4'd0},
        {3'b010, 7'h00, 2'b00,  4'd1,  8'h01, 2'b00, 4'd0},
        {3'b010, 7'h01, 2'b00,  4'd2,  8'h03, 2'b00, 4'd0},
        {3'b010, 7'h03, 2'b00,  4'd3,  8'h07, 2'b00, 4'd0},
        {3'b010, 7'h03, 2'b10,  4'd4,  8'h0F, 2'b00, 4'd0},
        {3'b010, 7'h07, 2'b10,  4'd5,  8'h1F, 2'b10, 4'd0},
        {3'b010, 7'h0F, 2'b10,  4'd6,  8'h3F, 2'b10, 4'd0},
        {3'b010, 7'h1F, 2'b10,  4'd7,  8'h7F, 2'b11, 4'd0},
        {3'b010, 7'h3F, 2'b10,  4'd8,  8'hFF, 2'b11, 4'd0},
        {3'b010, 7'h7F, 2'b10,  4'd9,  8'hFF, 2'b11, 4'd0},
        {3'b010, 7'h7F, 2'b10,  4'd9,  8'hFF, 2'b11, 4'd0},
        {3'b010, 7'h7F, 2'b11,  4'd10, 8'hFF, 2'b11, 4'd0},
        {3'b010, 7'h7F, 2'b11,  4'd10, 8'hFF, 2'b11, 4'd0},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'hFF, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h7F, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h3F, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h1F, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h0F, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h07, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h03, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h01, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd11, 8'h00, 2'b00, 4'd10},
        {3'b010, 7'h7F, 2'b10,  4'd0,  8'h00, 2'b00, 4'd10}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_until_leave(input logic [3:0] st, output int n);
        n = 0;
        while (seq_status == st && n < 100) begin
            step();
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; key_in = 1'b0; chg_det = 1'b0; bat_ins = 1'b0;
        pg_in = '0; clk_ready = 1'b0; keep_alive = 1'b0; pg_limit = 8'(LIM);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1", "status", seq_status, 0);
        chk("R1", "enables", en8, 0);
        chk("R1", "cpu_rst_n", cpu_rst_n, 0);
        chk("R1", "store_rst_n", store_rst_n, 0);
        chk("R1", "rtc_en", rtc_en, 1);
        chk("R1", "fault", fault_code, 0);

        // Full boot, run, keep-alive drop, shutdown (R2 R4 R5 R6 R10 R11)
        for (int i = 0; i < NVEC; i++) begin
            key_in     = BOOT_VEC[i][29];
            chg_det    = BOOT_VEC[i][28];
            bat_ins    = BOOT_VEC[i][27];
            pg_in      = BOOT_VEC[i][26:20];
            clk_ready  = BOOT_VEC[i][19];
            keep_alive = BOOT_VEC[i][18];
            step();
            chk("R2/R4", "status", seq_status, BOOT_VEC[i][17:14]);
            chk("R4/R11", "enables", en8, BOOT_VEC[i][13:6]);
            chk("R5", "cpu_rst_n", cpu_rst_n, BOOT_VEC[i][5]);
            chk("R6", "store_rst_n", store_rst_n, BOOT_VEC[i][4]);
            chk("R10", "fault", fault_code, BOOT_VEC[i][3:0]);
        end
        chg_det = 1'b0; pg_in = '0; clk_ready = 1'b0;
        step();

        // R3 debounce: short press ignored, held press wakes
        key_in = 1'b1;
        repeat (3) step();
        chk("R3", "short press status", seq_status, 0);
        key_in = 1'b0;
        step();
        key_in = 1'b1;
        repeat (4) step();
        chk("R3", "status at debounce limit", seq_status, 0);
        step();
        chk("R3", "status after press", seq_status, 1);
        key_in = 1'b0;

        // R7 R8 R11: core stage timeout aborts
        pg_in = 7'b1111011; clk_ready = 1'b1;
        repeat (3) step();
        chk("R8", "core status", seq_status, 4);
        chk("R5", "cpu_rst_n in core", cpu_rst_n, 0);
        run_until_leave(4'd4, n);
        chk("R7", "core stage cycles", n, LIM + 1);
        chk("R8", "abort status", seq_status, 11);
        chk("R7", "fault code core", fault_code, 4);
        chk("R8", "enables at abort", en8, 8'h0F);
        run_until_leave(4'd11, n);
        chk("R11", "shutdown cycles", n, 5);
        chk("R11", "standby status", seq_status, 0);
        chk("R11", "fault retained", fault_code, 4);
        chk("R11", "enables off", en8, 0);

        // R8 soft radio fault, R12 ignored wake, R9 handshake timeout
        pg_in = 7'b1011111; bat_ins = 1'b1;
        step();
        chk("R2", "battery wake", seq_status, 1);
        chk("R2", "fault cleared", fault_code, 0);
        repeat (6) step();
        chk("R4", "radio status", seq_status, 7);
        run_until_leave(4'd7, n);
        chk("R7", "radio stage cycles", n, LIM + 1);
        chk("R8", "soft continue status", seq_status, 8);
        chk("R8", "radio fault code", fault_code, 7);
        chk("R8", "radio enable kept", en8, 8'hFF);
        chk("R6", "storage reset released", store_rst_n, 1);
        step();
        chk("R4", "handshake status", seq_status, 9);
        chg_det = 1'b1;
        step();
        chk("R12", "status after wake in handshake", seq_status, 9);
        chk("R12", "fault after wake in handshake", fault_code, 7);
        run_until_leave(4'd9, n);
        chk("R9", "handshake cycles", n + 1, KA_TO + 1);
        chk("R9", "ka miss status", seq_status, 11);
        chk("R9", "ka miss fault", fault_code, 9);
        run_until_leave(4'd11, n);
        chk("R11", "back to standby", seq_status, 0);
        chg_det = 1'b0; bat_ins = 1'b0;
        step();

        // R5 keep-alive ignored early, R9 run entry, R10 drop
        pg_in = 7'h7F; clk_ready = 1'b1; keep_alive = 1'b1; chg_det = 1'b1;
        step();
        chk("R2", "charger wake", seq_status, 1);
        repeat (3) step();
        chk("R5", "core status with ka high", seq_status, 4);
        chk("R5", "cpu_rst_n held in core", cpu_rst_n, 0);
        step();
        chk("R5", "cpu_rst_n released in mem", cpu_rst_n, 1);
        repeat (4) step();
        chk("R5", "handshake not skipped", seq_status, 9);
        step();
        chk("R9", "run entry", seq_status, 10);
        chk("R9", "fault clear in run", fault_code, 0);
        keep_alive = 1'b0;
        step();
        chk("R10", "drop status", seq_status, 11);
        chk("R10", "drop fault", fault_code, 10);
        chk("R11", "cpu reset on shutdown", cpu_rst_n, 0);
        chk("R11", "store reset on shutdown", store_rst_n, 0);
        run_until_leave(4'd11, n);
        chk("R11", "full shutdown cycles", n, 9);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule